// File: doc/BRIEF.md
# Gated Interrupt and Timer Request Unit

This unit turns the interrupt sources of a small processor core into exception requests for the exception entry logic. It watches two external request pairs. One is an interrupt-controller pair of status and mask words. The other is a 16-bit DMA-controller pair. It also watches a compare value against its own cycle counter. The core's mode bits gate all of these: a global enable, an extra enable, an exception-level flag, an error-level flag, and one line-enable bit per source.

An enabled pending source from either controller is not taken at once. It starts a short countdown, and the request is made only if the source is still pending and enabled when the countdown ends. The timer source compares the internal counter against the compare value. It is accepted only inside a fixed window that starts at the compare value. The counter advances each clock by an elapsed-cycle amount supplied from outside. Each request is a one-cycle pulse that carries a cause code and the branch-delay flag. No new request is made until the previous one has been acknowledged.

Top module: `irq_gate`

## Requirements
- R1: A source can raise a request only while `ie_i`=1, `eie_i`=1, `exl_i`=0 and `erl_i`=0, and its line enable is set: `en_ictl_i` for the interrupt controller, `en_dma_i` for the DMA controller, `en_tmr_i` for the timer.
- R2: The interrupt-controller source is pending when the bitwise AND of `ictl_stat_i` and `ictl_mask_i` is non-zero.
- R3: The DMA source is pending when the AND of `dma_stat_i` and `dma_mask_i` is non-zero, or when bit 15 of `dma_mask_i` is set alone.
- R4: For a controller source first seen pending and enabled at clock edge E, `req_o` goes high after edge E+4, provided the source is still pending and enabled at that edge. If it is not, no request is made.
- R5: A controller request carries a `code_o` with bit 10 set if the interrupt-controller source is pending and bit 11 set if the DMA source is pending. All other bits are 0.
- R6: The timer source is pending when (count − `cmp_i`) modulo 2^32 is below 1000. It then raises `req_o` after the next clock edge, with `code_o` = 0x00808000.
- R7: `count_o` is 0 after reset. It adds `step_i` at every clock edge and wraps modulo 2^32.
- R8: `req_o` is high for exactly one cycle, and `bd_o` holds `bd_i` as sampled at that edge. After a request, `req_o` stays low until an edge at which `ack_i` is high has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ie_i | input | 1 | Global interrupt enable |
| eie_i | input | 1 | Extra interrupt enable |
| exl_i | input | 1 | Exception level active |
| erl_i | input | 1 | Error level active |
| en_ictl_i | input | 1 | Line enable, interrupt controller |
| en_dma_i | input | 1 | Line enable, DMA controller |
| en_tmr_i | input | 1 | Line enable, timer |
| ictl_stat_i | input | 16 | Interrupt-controller status word |
| ictl_mask_i | input | 16 | Interrupt-controller mask word |
| dma_stat_i | input | 16 | DMA-controller status word |
| dma_mask_i | input | 16 | DMA-controller mask word |
| cmp_i | input | 32 | Timer compare value |
| step_i | input | 8 | Cycles elapsed this clock |
| bd_i | input | 1 | Current instruction is in a branch-delay slot |
| ack_i | input | 1 | Acknowledge of the outstanding request |
| req_o | output | 1 | Exception request pulse |
| code_o | output | 32 | Cause code of the request |
| bd_o | output | 1 | Branch-delay flag of the request |
| count_o | output | 32 | Internal cycle counter |

## Verification
The assertions check the properties that hold on every cycle. The counter step is exact. Every pulse is one cycle wide. No pulse appears while a request is outstanding or while the mode bits block interrupts. A timer code only follows an enabled timer line, and a controller code always names at least one line. The bench scenarios cover the rest. They show the exact four-edge latency, the case where a source withdrawn before the countdown ends is dropped, the DMA mask-bit-15 trigger, both edges of the timer window, and a request that is re-raised after acknowledge.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int ICW  = 16,
  parameter int CW   = 32,
  parameter int SW   = 8,
  parameter int DLY  = 4,
  parameter int WIN  = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ie_i,
  input  logic           eie_i,
  input  logic           exl_i,
  input  logic           erl_i,
  input  logic           en_ictl_i,
  input  logic           en_dma_i,
  input  logic           en_tmr_i,
  input  logic [ICW-1:0] ictl_stat_i,
  input  logic [ICW-1:0] ictl_mask_i,
  input  logic [15:0]    dma_stat_i,
  input  logic [15:0]    dma_mask_i,
  input  logic [CW-1:0]  cmp_i,
  input  logic [SW-1:0]  step_i,
  input  logic           bd_i,
  input  logic           ack_i,
  output logic           req_o,
  output logic [31:0]    code_o,
  output logic           bd_o,
  output logic [CW-1:0]  count_o
);
  localparam int DW = $clog2(DLY + 1);
  localparam logic [31:0] TMR_CODE = 32'h0080_8000;

  logic [DW-1:0] dly;
  logic          busy;
  logic          past_ok;

  wire ints_ok = ie_i & eie_i & ~exl_i & ~erl_i;
  wire ic_hit  = en_ictl_i & (|(ictl_stat_i & ictl_mask_i));
  wire dm_hit  = en_dma_i & ((|(dma_stat_i & dma_mask_i)) | dma_mask_i[15]);
  wire src_hit = ints_ok & (ic_hit | dm_hit);

  wire [CW-1:0] since = count_o - cmp_i;
  wire tmr_hit = ints_ok & en_tmr_i & (since < CW'(WIN));

  wire expire   = (dly == DW'(1));
  wire fire_src = expire & src_hit & ~busy;
  wire fire_tmr = tmr_hit & ~busy & ~fire_src;
  wire fire     = fire_src | fire_tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      req_o   <= 1'b0;
      code_o  <= '0;
      bd_o    <= 1'b0;
      busy    <= 1'b0;
      dly     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      count_o <= count_o + CW'(step_i);
      req_o   <= fire;
      if (fire_src)
        code_o <= {20'b0, dm_hit, ic_hit, 10'b0};
      else if (fire_tmr)
        code_o <= TMR_CODE;
      if (fire) bd_o <= bd_i;
      if (fire)       busy <= 1'b1;
      else if (ack_i) busy <= 1'b0;
      if (dly != '0)    dly <= dly - DW'(1);
      else if (src_hit) dly <= DW'(DLY);
    end
  end

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> count_o == $past(count_o) + CW'($past(step_i)));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !req_o);

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ints_ok |=> !req_o);

  p_tmr_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && req_o && code_o == TMR_CODE) |-> $past(en_tmr_i));

  p_src_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && code_o != TMR_CODE) |-> (code_o[10] || code_o[11]));
endmodule

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ie_i = 0, eie_i = 0, exl_i = 0, erl_i = 0;
  logic en_ictl_i = 0, en_dma_i = 0, en_tmr_i = 0;
  logic [15:0] ictl_stat_i = 0, ictl_mask_i = 0, dma_stat_i = 0, dma_mask_i = 0;
  logic [31:0] cmp_i = 0;
  logic [7:0]  step_i = 0;
  logic bd_i = 0, ack_i = 0;
  logic req_o, bd_o;
  logic [31:0] code_o, count_o;

  int checks = 0, errors = 0;

  irq_gate u_dut (
    .clk(clk), .rst_n(rst_n), .ie_i(ie_i), .eie_i(eie_i), .exl_i(exl_i), .erl_i(erl_i),
    .en_ictl_i(en_ictl_i), .en_dma_i(en_dma_i), .en_tmr_i(en_tmr_i),
    .ictl_stat_i(ictl_stat_i), .ictl_mask_i(ictl_mask_i),
    .dma_stat_i(dma_stat_i), .dma_mask_i(dma_mask_i), .cmp_i(cmp_i), .step_i(step_i),
    .bd_i(bd_i), .ack_i(ack_i), .req_o(req_o), .code_o(code_o), .bd_o(bd_o), .count_o(count_o)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    ie_i = 0; eie_i = 0; exl_i = 0; erl_i = 0;
    en_ictl_i = 0; en_dma_i = 0; en_tmr_i = 0;
    ictl_stat_i = 0; ictl_mask_i = 0; dma_stat_i = 0; dma_mask_i = 0;
    cmp_i = 0; step_i = 0; bd_i = 0; ack_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); quiet(); rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic mode_ok();
    ie_i = 1; eie_i = 1; exl_i = 0; erl_i = 0;
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (req_o) p++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(req_o == 0, "R8 reset req", req_o, 0);
    check(count_o == 0, "R7 reset count", count_o, 0);
  endtask

  task automatic t_ictl_latency();
    int p;
    do_reset();
    mode_ok(); en_ictl_i = 1; ictl_stat_i = 16'h0005; ictl_mask_i = 16'h0004; bd_i = 1;
    for (int i = 0; i < 4; i++) tick();
    check(req_o == 0, "R4 early req", req_o, 0);
    tick();
    check(req_o == 1, "R4 req at fourth edge", req_o, 1);
    check(code_o == 32'h400, "R5 ictl code", code_o, 32'h400);
    check(bd_o == 1, "R8 bd captured", bd_o, 1);
    bd_i = 0;
    tick();
    check(req_o == 0, "R8 pulse width", req_o, 0);
    count_pulses(10, p);
    check(p == 0, "R8 held until ack", p, 0);
    ack_i = 1; tick(); ack_i = 0;
    count_pulses(10, p);
    check(p == 1, "R8 re-raise after ack", p, 1);
    check(bd_o == 0, "R8 bd of second request", bd_o, 0);
  endtask

  task automatic t_ictl_nomatch();
    int p;
    do_reset();
    mode_ok(); en_ictl_i = 1; ictl_stat_i = 16'h00F0; ictl_mask_i = 16'h0F0F;
    count_pulses(10, p);
    check(p == 0, "R2 disjoint stat and mask", p, 0);
  endtask

  task automatic t_dma();
    int p;
    do_reset();
    mode_ok(); en_dma_i = 1; dma_stat_i = 16'h0102; dma_mask_i = 16'h0002;
    for (int i = 0; i < 5; i++) tick();
    check(req_o == 1, "R3 dma and-match req", req_o, 1);
    check(code_o == 32'h800, "R5 dma code", code_o, 32'h800);
    do_reset();
    mode_ok(); en_dma_i = 1; dma_stat_i = 16'h0000; dma_mask_i = 16'h8000;
    for (int i = 0; i < 5; i++) tick();
    check(req_o == 1, "R3 dma mask bit15 req", req_o, 1);
    do_reset();
    mode_ok(); en_dma_i = 1; en_ictl_i = 1; dma_mask_i = 16'h8000;
    ictl_stat_i = 16'h0001; ictl_mask_i = 16'h0001;
    for (int i = 0; i < 5; i++) tick();
    check(code_o == 32'hC00 && req_o, "R5 both lines code", code_o, 32'hC00);
    do_reset();
    mode_ok(); en_dma_i = 1; dma_stat_i = 16'h4000; dma_mask_i = 16'h0001;
    count_pulses(10, p);
    check(p == 0, "R3 no dma match", p, 0);
  endtask

  task automatic t_gating();
    int p;
    for (int k = 0; k < 5; k++) begin
      do_reset();
      mode_ok(); en_ictl_i = 1; ictl_stat_i = 16'h1; ictl_mask_i = 16'h1;
      case (k)
        0: ie_i = 0;
        1: eie_i = 0;
        2: exl_i = 1;
        3: erl_i = 1;
        default: en_ictl_i = 0;
      endcase
      count_pulses(10, p);
      check(p == 0, $sformatf("R1 blocked case %0d", k), p, 0);
    end
  endtask

  task automatic t_withdraw();
    int p;
    do_reset();
    mode_ok(); en_ictl_i = 1; ictl_stat_i = 16'h1; ictl_mask_i = 16'h1;
    tick(); tick();
    ictl_stat_i = 16'h0;
    count_pulses(8, p);
    check(p == 0, "R4 withdrawn before countdown", p, 0);
  endtask

  task automatic set_count(input int unsigned amt);
    while (amt > 0) begin
      step_i = (amt > 255) ? 8'd255 : 8'(amt);
      amt -= step_i;
      tick();
    end
    step_i = 0;
  endtask

  task automatic tmr_probe(input bit expect_hit, input string tag);
    en_tmr_i = 1;
    tick();
    check(req_o == expect_hit, tag, req_o, expect_hit);
    if (expect_hit)
      check(code_o == 32'h0080_8000, "R6 timer code", code_o, 32'h0080_8000);
    en_tmr_i = 0; ack_i = 1; tick(); ack_i = 0; tick();
  endtask

  task automatic t_timer();
    int p;
    do_reset();
    mode_ok(); cmp_i = 32'd1000;
    set_count(999);
    check(count_o == 999, "R7 count accumulates", count_o, 999);
    tmr_probe(0, "R6 below compare");
    set_count(1);
    tmr_probe(1, "R6 at compare");
    set_count(999);
    tmr_probe(1, "R6 top of window");
    set_count(1);
    tmr_probe(0, "R6 past window");
    do_reset();
    mode_ok(); cmp_i = 32'd10; set_count(10);
    count_pulses(4, p);
    check(p == 0, "R6 timer line disabled", p, 0);
    ie_i = 0; en_tmr_i = 1;
    count_pulses(4, p);
    check(p == 0, "R1 timer blocked by ie", p, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ictl_latency();
    t_ictl_nomatch();
    t_dma();
    t_gating();
    t_withdraw();
    t_timer();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule